// File: doc/BRIEF.md
# AHB Burst Transfer Sequencer

This block sits on the master side of an AHB-style bus and produces the address phase of every transfer: HTRANS, HADDR, HBURST, HSIZE, HWRITE and HPROT. A local agent gives it one command at a time, made of a start address, burst kind, transfer size, direction and, for undefined-length bursts, a beat count. The sequencer then steps through the beats and follows HREADY and the two-bit HRESP returned for each data phase.

The bus rules for wait states are enforced in the registers themselves. An address phase that has been offered stays frozen until the slave takes it. A stall request from the local side is turned into BUSY cycles only inside undefined-length bursts. A non-OKAY response is answered with IDLE in the second response cycle. An ERROR abandons the rest of the command. RETRY and SPLIT make the block re-issue the failed beat as a fresh NONSEQ and continue from there. The local side sees a one-cycle `done_o` or `abort_o` pulse when a command finishes.

Top module: `ahb_burst_seq`

## Requirements
- R1: While reset is held and right after it, htrans_o is IDLE (2'b00), haddr_o, hburst_o, hsize_o and hwrite_o are 0, hprot_o is 4'b0011, done_o and abort_o are 0 and cmd_ready_o is 1.
- R2: With cmd_ready_o high, a command seen at a clock edge is shown as NONSEQ (2'b10) at its start address from the next cycle, whatever the level of hready_i was at that edge.
- R3: While hready_i is low, the response is OKAY and htrans_o is NONSEQ or SEQ, htrans_o, haddr_o, hburst_o, hsize_o and hwrite_o keep their values into the next cycle.
- R4: HTRANS codes are IDLE 0, BUSY 1, NONSEQ 2, SEQ 3. HBURST codes are SINGLE 0, INCR 1, WRAP4 2, INCR4 3, WRAP8 4, INCR8 5, WRAP16 6, INCR16 7. A non-wrapping burst raises the address by 2^size bytes per beat. SINGLE has one beat, INCRn has n beats, and INCR has cmd_len_i beats, with 0 counted as 1.
- R5: A wrapping burst of n beats keeps every address inside the aligned block of n * 2^size bytes that holds the start address, and wraps to the block's base after the top.
- R6: With stall_i high when a beat of an INCR burst is taken and beats remain, the next cycle shows BUSY (1) with the next beat's address. BUSY and its address hold while stall_i stays high, and SEQ follows the cycle after stall_i drops. When the last beat is taken, IDLE follows, never BUSY.
- R7: stall_i has no effect in SINGLE, INCRn and WRAPn bursts: BUSY never appears and the beats run back to back.
- R8: A non-OKAY hresp_i (ERROR 1, RETRY 2, SPLIT 3) with hready_i low while a data phase is pending makes htrans_o IDLE in the next cycle.
- R9: After the second cycle of an ERROR response, no further beat of the command is issued and abort_o is high for exactly the next cycle. done_o does not pulse for that command.
- R10: After the second cycle of a RETRY or SPLIT response, the failed beat is shown again as NONSEQ at its own address, and the remaining beats follow. hburst_o keeps the command's code if the failed beat was the first, and becomes INCR otherwise.
- R11: hsize_o and hwrite_o stay constant from NONSEQ through every SEQ and BUSY of a burst, and hprot_o is always 4'b0011.
- R12: done_o is high for exactly one cycle, the cycle after the last beat's data phase ends with hready_i high and OKAY. cmd_ready_o is low from command acceptance until that data phase has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_addr_i | input | AW | Start byte address |
| cmd_burst_i | input | 3 | Burst kind, HBURST code |
| cmd_size_i | input | 3 | log2 of bytes per beat |
| cmd_write_i | input | 1 | 1 for write |
| cmd_len_i | input | LW | Beat count for INCR bursts |
| stall_i | input | 1 | Local side needs a pause between beats |
| hready_i | input | 1 | Bus transfer done / address taken |
| hresp_i | input | 2 | Slave response |
| htrans_o | output | 2 | Transfer type |
| haddr_o | output | AW | Address |
| hburst_o | output | 3 | Burst kind |
| hsize_o | output | 3 | Transfer size |
| hwrite_o | output | 1 | Direction |
| hprot_o | output | 4 | Protection attributes |
| done_o | output | 1 | Command finished with OKAY |
| abort_o | output | 1 | Command cancelled by ERROR |

## Verification
The assertions check, on every cycle, that an offered NONSEQ or SEQ stays frozen through OKAY wait states. They also check that BUSY only shows up in INCR bursts with its address held, that the cycle after a first non-OKAY response cycle is IDLE, that size and direction stay put across SEQ and BUSY, and that done_o and abort_o each follow the right kind of completed response. Whether the address sequence is right, wrap included, which beat is re-issued after RETRY or SPLIT, whether the burst code changes on a partial restart, and whether ERROR really drops the remaining beats can only be shown by the scenarios. There, a behavioural model of the expected bus trace is compared with the outputs, and the list of accepted addresses is checked against literal lists.

// File: rtl/ahb_seq_pkg.sv
package ahb_seq_pkg;
  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  localparam logic [1:0] RS_OKAY  = 2'd0;
  localparam logic [1:0] RS_ERROR = 2'd1;

  localparam logic [2:0] BU_SINGLE = 3'd0;
  localparam logic [2:0] BU_INCR   = 3'd1;

  localparam logic [3:0] PROT_DEFAULT = 4'b0011;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP2} seq_st_e;
endpackage

// File: rtl/ahb_beat_cfg.sv
module ahb_beat_cfg
  import ahb_seq_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [2:0]    burst_i,
  input  logic [LW-1:0] len_i,
  output logic [LW-1:0] beats_o,
  output logic          wrap_o,
  output logic [2:0]    wrap_lg_o
);
  // burst_i[2:1] selects 4/8/16 beats, burst_i[0]==0 marks wrapping
  always_comb begin
    wrap_lg_o = {1'b0, burst_i[2:1]} + 3'd1;
    wrap_o    = (burst_i[2:1] != 2'b00) && !burst_i[0];
    if (burst_i == BU_SINGLE)    beats_o = LW'(1);
    else if (burst_i == BU_INCR) beats_o = (len_i == '0) ? LW'(1) : len_i;
    else                         beats_o = LW'(1) << wrap_lg_o;
  end
endmodule

// File: rtl/ahb_addr_step.sv
module ahb_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic          wrap_i,
  input  logic [2:0]    wrap_lg_i,
  output logic [AW-1:0] next_o
);
  logic [3:0]    blk_sh;
  logic [AW-1:0] step, sum, mask;

  always_comb begin
    step   = AW'(1) << size_i;
    sum    = addr_i + step;
    blk_sh = {1'b0, wrap_lg_i} + {1'b0, size_i};
    mask   = (AW'(1) << blk_sh) - AW'(1);
    next_o = wrap_i ? ((addr_i & ~mask) | (sum & mask)) : sum;
  end
endmodule

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq
  import ahb_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [2:0]    cmd_burst_i,
  input  logic [2:0]    cmd_size_i,
  input  logic          cmd_write_i,
  input  logic [LW-1:0] cmd_len_i,
  input  logic          stall_i,
  input  logic          hready_i,
  input  logic [1:0]    hresp_i,
  output logic [1:0]    htrans_o,
  output logic [AW-1:0] haddr_o,
  output logic [2:0]    hburst_o,
  output logic [2:0]    hsize_o,
  output logic          hwrite_o,
  output logic [3:0]    hprot_o,
  output logic          done_o,
  output logic          abort_o
);
  seq_st_e       st_q;
  logic [1:0]    trans_q;
  logic [AW-1:0] addr_q, dp_addr_q, next_addr;
  logic [2:0]    burst_q, size_q, lg_q, cfg_lg;
  logic          write_q, wrap_q, cfg_wrap;
  logic [LW-1:0] total_q, left_q, dp_left_q, cfg_beats;
  logic          dp_valid_q, resp_err_q, done_q, abort_q;
  logic          xfer, resp_first;

  ahb_beat_cfg #(.LW(LW)) u_cfg (
    .burst_i  (cmd_burst_i),
    .len_i    (cmd_len_i),
    .beats_o  (cfg_beats),
    .wrap_o   (cfg_wrap),
    .wrap_lg_o(cfg_lg)
  );

  ahb_addr_step #(.AW(AW)) u_step (
    .addr_i   (addr_q),
    .size_i   (size_q),
    .wrap_i   (wrap_q),
    .wrap_lg_i(lg_q),
    .next_o   (next_addr)
  );

  assign xfer        = hready_i && trans_q[1];
  assign resp_first  = dp_valid_q && !hready_i && (hresp_i != RS_OKAY);
  assign cmd_ready_o = (st_q == ST_IDLE) && !dp_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      trans_q    <= TR_IDLE;
      addr_q     <= '0;
      burst_q    <= BU_SINGLE;
      size_q     <= '0;
      write_q    <= 1'b0;
      wrap_q     <= 1'b0;
      lg_q       <= '0;
      total_q    <= '0;
      left_q     <= '0;
      dp_valid_q <= 1'b0;
      dp_addr_q  <= '0;
      dp_left_q  <= '0;
      resp_err_q <= 1'b0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (st_q == ST_RESP2) begin
        if (hready_i) begin
          dp_valid_q <= 1'b0;
          if (resp_err_q) begin
            st_q    <= ST_IDLE;
            trans_q <= TR_IDLE;
            abort_q <= 1'b1;
          end else begin
            // re-issue the failed beat; mid-burst restart becomes undefined length
            st_q    <= ST_RUN;
            trans_q <= TR_NONSEQ;
            addr_q  <= dp_addr_q;
            left_q  <= dp_left_q;
            if (dp_left_q != total_q) burst_q <= BU_INCR;
          end
        end
      end else if (resp_first) begin
        st_q       <= ST_RESP2;
        trans_q    <= TR_IDLE;
        resp_err_q <= (hresp_i == RS_ERROR);
      end else begin
        if (hready_i) begin
          done_q     <= dp_valid_q && (dp_left_q == LW'(1)) && (hresp_i == RS_OKAY);
          dp_valid_q <= xfer;
          if (xfer) begin
            dp_addr_q <= addr_q;
            dp_left_q <= left_q;
          end
        end
        case (st_q)
          ST_IDLE: begin
            if (cmd_valid_i && cmd_ready_o) begin
              st_q    <= ST_RUN;
              trans_q <= TR_NONSEQ;
              addr_q  <= cmd_addr_i;
              burst_q <= cmd_burst_i;
              size_q  <= cmd_size_i;
              write_q <= cmd_write_i;
              wrap_q  <= cfg_wrap;
              lg_q    <= cfg_lg;
              total_q <= cfg_beats;
              left_q  <= cfg_beats;
            end
          end
          ST_RUN: begin
            if (trans_q == TR_BUSY) begin
              if (!stall_i) trans_q <= TR_SEQ;
            end else if (xfer) begin
              if (left_q == LW'(1)) begin
                st_q    <= ST_IDLE;
                trans_q <= TR_IDLE;
              end else begin
                left_q  <= left_q - LW'(1);
                addr_q  <= next_addr;
                trans_q <= (stall_i && burst_q == BU_INCR) ? TR_BUSY : TR_SEQ;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign htrans_o = trans_q;
  assign haddr_o  = addr_q;
  assign hburst_o = burst_q;
  assign hsize_o  = size_q;
  assign hwrite_o = write_q;
  assign hprot_o  = PROT_DEFAULT;
  assign done_o   = done_q;
  assign abort_o  = abort_q;
endmodule

// File: rtl/ahb_burst_seq_chk.sv
module ahb_burst_seq_chk
  import ahb_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hready_i,
  input logic [1:0]    hresp_i,
  input logic [1:0]    htrans_o,
  input logic [AW-1:0] haddr_o,
  input logic [2:0]    hburst_o,
  input logic [2:0]    hsize_o,
  input logic          hwrite_o,
  input logic          done_o,
  input logic          abort_o
);
  a_r3_hold_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hready_i && htrans_o[1] && hresp_i == RS_OKAY) |=>
      ($stable(htrans_o) && $stable(haddr_o) && $stable(hburst_o) &&
       $stable(hsize_o) && $stable(hwrite_o)));

  a_r6_busy_incr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_BUSY) |-> (hburst_o == BU_INCR));

  a_r6_busy_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_BUSY) |=> $stable(haddr_o));

  a_r8_idle_after_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hready_i && hresp_i != RS_OKAY) |=> (htrans_o == TR_IDLE));

  a_r11_ctrl_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_SEQ || htrans_o == TR_BUSY) |->
      ($stable(hsize_o) && $stable(hwrite_o) && $stable(hburst_o)));

  a_r9_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(hready_i && hresp_i == RS_ERROR));

  a_r12_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(hready_i && hresp_i == RS_OKAY) && !abort_o));
endmodule

bind ahb_burst_seq ahb_burst_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ahb_burst_seq.sv
module tb_ahb_burst_seq;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam logic [1:0] OK = 2'd0, ERR = 2'd1, RTY = 2'd2, SPL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 0, cmd_write = 0, stall = 0, hready = 1;
  logic [AW-1:0] cmd_addr = '0;
  logic [2:0]    cmd_burst = '0, cmd_size = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [1:0]    hresp = OK;
  logic          cmd_ready, hwrite, done, abort;
  logic [1:0]    htrans;
  logic [AW-1:0] haddr;
  logic [2:0]    hburst, hsize;
  logic [3:0]    hprot;

  ahb_burst_seq #(.AW(AW), .LW(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_burst_i(cmd_burst), .cmd_size_i(cmd_size),
    .cmd_write_i(cmd_write), .cmd_len_i(cmd_len), .stall_i(stall),
    .hready_i(hready), .hresp_i(hresp), .htrans_o(htrans), .haddr_o(haddr),
    .hburst_o(hburst), .hsize_o(hsize), .hwrite_o(hwrite), .hprot_o(hprot),
    .done_o(done), .abort_o(abort)
  );

  int total = 0, bad = 0, n_done = 0, n_abort = 0, n_busy = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [AW-1:0] acc[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_mode, m_idx, m_pend, m_total;
  bit m_err;
  logic [1:0] m_trans;
  logic [AW-1:0] m_addr;
  logic [2:0] m_burst, m_size;
  logic m_write, m_done, m_abort;
  logic [AW-1:0] m_list[$];

  function automatic int beat_count(input logic [2:0] b, input logic [LW-1:0] l);
    case (b)
      3'd0: return 1;
      3'd1: return (l == 0) ? 1 : int'(l);
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int old_pend, n;
    logic [AW-1:0] incr, bound, base;
    if (!rst_n) begin
      m_mode = 0; m_idx = 0; m_pend = -1; m_total = 0; m_err = 0;
      m_trans = 0; m_addr = 0; m_burst = 0; m_size = 0; m_write = 0;
      m_done = 0; m_abort = 0;
    end else begin
      old_pend = m_pend;
      m_done = 0; m_abort = 0;
      if (m_mode == 2) begin
        if (hready) begin
          if (m_err) begin
            m_mode = 0; m_trans = 0; m_abort = 1;
          end else begin
            m_mode = 1; m_idx = m_pend; m_trans = 2; m_addr = m_list[m_idx];
            if (m_idx != 0) m_burst = 3'd1;
          end
          m_pend = -1;
        end
      end else if (m_pend >= 0 && !hready && hresp != OK) begin
        m_mode = 2; m_trans = 0; m_err = (hresp == ERR);
      end else begin
        if (hready) begin
          if (m_pend >= 0 && m_pend == m_total - 1 && hresp == OK) m_done = 1;
          m_pend = (m_trans >= 2) ? m_idx : -1;
        end
        if (m_mode == 0) begin
          if (cmd_valid && old_pend < 0) begin
            n = beat_count(cmd_burst, cmd_len);
            incr = 1 << cmd_size;
            m_list.delete();
            if (cmd_burst >= 2 && cmd_burst[0] == 0) begin
              bound = AW'(n) * incr;
              base = cmd_addr - (cmd_addr % bound);
              for (int k = 0; k < n; k++)
                m_list.push_back(base + ((cmd_addr - base) + AW'(k) * incr) % bound);
            end else begin
              for (int k = 0; k < n; k++) m_list.push_back(cmd_addr + AW'(k) * incr);
            end
            m_total = n; m_idx = 0; m_mode = 1; m_trans = 2; m_addr = cmd_addr;
            m_burst = cmd_burst; m_size = cmd_size; m_write = cmd_write;
          end
        end else begin
          if (m_trans == 1) begin
            if (!stall) m_trans = 3;
          end else if (hready && m_trans >= 2) begin
            if (m_idx == m_total - 1) begin
              m_trans = 0; m_mode = 0;
            end else begin
              m_idx++; m_addr = m_list[m_idx];
              m_trans = (stall && m_burst == 3'd1) ? 2'd1 : 2'd3;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(htrans == m_trans, cur_req, "htrans", AW'(htrans), AW'(m_trans));
      chk(haddr == m_addr, cur_req, "haddr", haddr, m_addr);
      chk(hburst == m_burst, cur_req, "hburst", AW'(hburst), AW'(m_burst));
      chk(hsize == m_size, "R11", "hsize", AW'(hsize), AW'(m_size));
      chk(hwrite == m_write, "R11", "hwrite", AW'(hwrite), AW'(m_write));
      chk(hprot == 4'b0011, "R11", "hprot", AW'(hprot), 32'h3);
      chk(done == m_done, "R12", "done", AW'(done), AW'(m_done));
      chk(abort == m_abort, "R9", "abort", AW'(abort), AW'(m_abort));
      chk(cmd_ready == (m_mode == 0 && m_pend < 0), "R12", "cmd_ready",
          AW'(cmd_ready), AW'(m_mode == 0 && m_pend < 0));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic v, input logic st, input logic rdy, input logic [1:0] rsp);
    @(negedge clk);
    cmd_valid = v; stall = st; hready = rdy; hresp = rsp;
    #1;
    if (hready && htrans[1]) acc.push_back(haddr);
    if (done) n_done++;
    if (abort) n_abort++;
    if (htrans == 2'd1) n_busy++;
    @(posedge clk);
    #2;
  endtask

  task automatic set_cmd(input logic [AW-1:0] a, input logic [2:0] b, input logic [2:0] s,
                         input logic w, input logic [LW-1:0] l);
    cmd_addr = a; cmd_burst = b; cmd_size = s; cmd_write = w; cmd_len = l;
  endtask

  task automatic run_ok(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, OK);
  endtask

  task automatic start_scn(input string req);
    cur_req = req;
    acc.delete();
    n_done = 0; n_abort = 0; n_busy = 0;
  endtask

  task automatic chk_list(input string req, input logic [AW-1:0] exp[$]);
    chk(acc.size() == exp.size(), req, "beats taken", AW'(acc.size()), AW'(exp.size()));
    for (int i = 0; i < exp.size() && i < acc.size(); i++)
      chk(acc[i] == exp[i], req, "taken addr", acc[i], exp[i]);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] a0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values while reset held
    chk(htrans == 2'd0, "R1", "htrans in reset", AW'(htrans), 0);
    chk(hprot == 4'b0011, "R1", "hprot in reset", AW'(hprot), 32'h3);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk(haddr == 0 && hburst == 0 && hsize == 0 && hwrite == 0, "R1", "ctrl after reset",
        haddr, 0);
    chk(cmd_ready == 1 && done == 0 && abort == 0, "R1", "ready after reset",
        AW'(cmd_ready), 1);

    // R4 / R12: INCR4 write, no waits
    start_scn("R4");
    set_cmd(32'h100, 3'd3, 3'd2, 1'b1, 8'd0);
    cyc(1, 0, 1, OK);
    cyc(0, 0, 1, OK);
    chk(hsize == 3'd2 && hwrite == 1 && hprot == 4'b0011, "R11", "ctrl mid burst",
        AW'(hsize), 2);
    chk(cmd_ready == 0, "R12", "busy mid burst", AW'(cmd_ready), 0);
    run_ok(5);
    chk_list("R4", '{32'h100, 32'h104, 32'h108, 32'h10c});
    chk(n_done == 1, "R12", "done pulses", AW'(n_done), 1);

    // R5: wrapping bursts
    start_scn("R5");
    set_cmd(32'h38, 3'd2, 3'd2, 1'b0, 8'd0);
    cyc(1, 0, 1, OK); run_ok(6);
    chk_list("R5", '{32'h38, 32'h3c, 32'h30, 32'h34});
    start_scn("R5");
    set_cmd(32'h2b, 3'd6, 3'd0, 1'b0, 8'd0);
    cyc(1, 0, 1, OK); run_ok(19);
    chk(acc.size() == 16, "R5", "wrap16 beats", AW'(acc.size()), 16);
    if (acc.size() == 16) begin
      chk(acc[4] == 32'h2f && acc[5] == 32'h20, "R5", "wrap16 turn", acc[5], 32'h20);
      chk(acc[15] == 32'h2a, "R5", "wrap16 last", acc[15], 32'h2a);
    end

    // R2 / R3: command while hready low, then wait states
    start_scn("R2");
    cyc(0, 0, 0, OK);
    set_cmd(32'h40, 3'd0, 3'd2, 1'b1, 8'd0);
    cyc(1, 0, 0, OK);
    chk(htrans == 2'd2 && haddr == 32'h40, "R2", "nonseq under wait", AW'(htrans), 2);
    cur_req = "R3";
    cyc(0, 0, 0, OK); cyc(0, 0, 0, OK);
    chk(htrans == 2'd2 && haddr == 32'h40, "R3", "held in wait", haddr, 32'h40);
    run_ok(4);
    chk_list("R3", '{32'h40});

    // R6: BUSY in an INCR burst of 5
    start_scn("R6");
    set_cmd(32'h300, 3'd1, 3'd2, 1'b0, 8'd5);
    cyc(1, 0, 1, OK);
    cyc(0, 1, 1, OK);
    cyc(0, 1, 1, OK);
    chk(htrans == 2'd1 && haddr == 32'h304, "R6", "busy shows next", haddr, 32'h304);
    cyc(0, 0, 1, OK);
    chk(htrans == 2'd3 && haddr == 32'h304, "R6", "seq after busy", AW'(htrans), 3);
    cyc(0, 0, 0, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 1, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 1, 1, OK);
    chk(htrans == 2'd0, "R6", "idle after last", AW'(htrans), 0);
    cyc(0, 1, 1, OK);
    run_ok(2);
    chk_list("R6", '{32'h300, 32'h304, 32'h308, 32'h30c, 32'h310});

    // R7: stall ignored in INCR8
    start_scn("R7");
    set_cmd(32'h400, 3'd5, 3'd2, 1'b1, 8'd3);
    cyc(1, 1, 1, OK);
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, OK);
    chk(n_busy == 0, "R7", "busy cycles", AW'(n_busy), 0);
    chk(acc.size() == 8, "R7", "beats back to back", AW'(acc.size()), 8);
    run_ok(1);

    // R8 / R9: ERROR cancels a WRAP4
    start_scn("R9");
    set_cmd(32'h58, 3'd2, 3'd2, 1'b0, 8'd0);
    cyc(1, 0, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 0, 0, ERR);
    chk(htrans == 2'd0, "R8", "idle in 2nd resp cycle", AW'(htrans), 0);
    cyc(0, 0, 1, ERR);
    chk(abort == 1, "R9", "abort pulse", AW'(abort), 1);
    run_ok(4);
    chk_list("R9", '{32'h58});
    chk(n_done == 0 && n_abort == 1, "R9", "no done after error", AW'(n_done), 0);

    // R10: RETRY mid INCR4
    start_scn("R10");
    set_cmd(32'h200, 3'd3, 3'd2, 1'b0, 8'd0);
    cyc(1, 0, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 0, 0, RTY);
    chk(htrans == 2'd0, "R8", "idle on retry", AW'(htrans), 0);
    cyc(0, 0, 1, RTY);
    chk(htrans == 2'd2 && haddr == 32'h204, "R10", "retry reissue", haddr, 32'h204);
    chk(hburst == 3'd1, "R10", "partial restart burst", AW'(hburst), 1);
    run_ok(6);
    chk_list("R10", '{32'h200, 32'h204, 32'h204, 32'h208, 32'h20c});
    chk(n_done == 1, "R10", "done after retry", AW'(n_done), 1);

    // R10: SPLIT on first beat of WRAP8
    start_scn("R10");
    set_cmd(32'h0e, 3'd4, 3'd1, 1'b1, 8'd0);
    cyc(1, 0, 1, OK);
    cyc(0, 0, 1, OK);
    cyc(0, 0, 0, SPL);
    cyc(0, 0, 1, SPL);
    chk(htrans == 2'd2 && haddr == 32'h0e, "R10", "split reissue", haddr, 32'h0e);
    chk(hburst == 3'd4, "R10", "full restart burst", AW'(hburst), 4);
    run_ok(12);
    a0 = (acc.size() > 2) ? acc[2] : '1;
    chk(acc.size() == 9, "R10", "split beats", AW'(acc.size()), 9);
    chk(a0 == 32'h00, "R5", "wrap8 turn", a0, 32'h00);
    chk(n_done == 1, "R12", "done after split", AW'(n_done), 1);

    finish_run();
  end
endmodule